// File: doc/BRIEF.md
# Configuration frame decoder

This block sits behind a line decoder that has already turned pulse widths into bits. It parses one configuration/status frame at a time. Each frame starts with a read/write flag and a 4-bit subcommand index. A data field follows, and its length is fixed per index. The frame closes with an 8-bit checksum. A write frame whose checksum is good is committed into a bit-addressable parameter store, and a one-bit acknowledge is returned. A read frame makes the block send out the stored field, followed by a checksum that it computes over the field.

The checksum is the one's complement of an 8-bit sum in which each carry out of bit 7 is added back in at bit 0. The bits are grouped into bytes, the first bit of each byte being its MSB. A final short byte is padded with zeros before it is added. For a read, the sum starts with a command byte made of four zero bits followed by the index. That byte is only counted, never sent.

Top module: `cfg_frame_parser`

## Requirements
- R1: After reset the block is idle, `tx_valid_o` is low and every stored field reads back as all zeros.
- R2: A `frame_start_i` pulse while idle opens a frame. The bits that follow, one per cycle with `bit_valid_i` high, are the R/W flag (1 = write, 0 = read) and then the 4 index bits, MSB first. Bits that arrive while idle are ignored, including one in the same cycle as the start pulse.
- R3: Data length in bits by index: 0:8, 1:24, 2:8, 3:18, 4:8, 5:124, 6:124, 7:42, 8:56, 9:160, 10:46, 11:8, 12:1024, 13:352, 15:16. Index 14 carries no data.
- R4: For a write, the checksum covers the R/W flag, the index and the data, and is received MSB first. For a read, it covers the unsent command byte {0000, index} and then the data, and is sent MSB first after the data.
- R5: When a write checksum matches, the field is committed on the edge that takes the last checksum bit. In the next cycle `tx_valid_o` is high for exactly one cycle with `tx_bit_o` = 1.
- R6: When a write checksum does not match, the acknowledge is 0 and the store is left unchanged.
- R7: A write to index 0, 1, 12, 15 or 14 (14 takes no data bits) gets acknowledge 0 and changes nothing.
- R8: A read starts in the cycle after the fifth command bit. `tx_valid_o` then stays high for length+8 cycles: first the data bits in stored order (the first data bit written is the first bit sent), then the checksum. A read of index 14 sends nothing.
- R9: Bits beyond the end of a frame, arriving during the acknowledge, the read transmission or idle, are ignored.
- R10: A `frame_start_i` pulse while a frame or a transmission is active has no effect.
- R11: `timeout_i` returns the block to idle on the next edge from any state. It sends no acknowledge, commits nothing and cuts a read transmission short.
- R12: Input bits may be separated by any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Start of a configuration frame |
| bit_valid_i | input | 1 | Strobe for `bit_i` |
| bit_i | input | 1 | Decoded frame bit |
| timeout_i | input | 1 | Abort the current frame |
| tx_valid_o | output | 1 | Response bit is valid this cycle |
| tx_bit_o | output | 1 | Acknowledge, read data or read checksum bit |

## Verification
The cases hardest to reach are those where something arrives against an active frame. A start pulse can land in the middle of a data field. Surplus bits can fall into the acknowledge cycle or into a read transmission. A timeout can cut into a long read. The bench reaches them by building frames bit by bit with selectable spacing, inserting a start pulse or a timeout at a chosen bit, and appending surplus bits to complete frames. Each cycle it compares the response against a queue-based model, and it reads the fields back to confirm that rejected frames left them unchanged.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned NUM_IDX = 1 << IDX_W;
  localparam int unsigned CSUM_W  = 8;
  localparam int unsigned CNT_W   = 11;

  function automatic int unsigned sub_len(input int unsigned i);
    case (i)
      0, 2, 4, 11: return 8;
      1:           return 24;
      3:           return 18;
      5, 6:        return 124;
      7:           return 42;
      8:           return 56;
      9:           return 160;
      10:          return 46;
      12:          return 1024;
      13:          return 352;
      15:          return 16;
      default:     return 0;
    endcase
  endfunction

  function automatic bit sub_wr(input int unsigned i);
    return (i < NUM_IDX) && !(i inside {0, 1, 12, 14, 15});
  endfunction

  function automatic int unsigned sub_off(input int unsigned i);
    int unsigned acc = 0;
    for (int unsigned j = 0; j < NUM_IDX; j++)
      if (j < i) acc += sub_len(j);
    return acc;
  endfunction

  function automatic int unsigned total_len();
    return sub_off(NUM_IDX);
  endfunction

  function automatic int unsigned stage_len();
    int unsigned m = 1;
    for (int unsigned j = 0; j < NUM_IDX; j++)
      if (sub_wr(j) && sub_len(j) > m) m = sub_len(j);
    return m;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_CSUM, ST_ACK, ST_READ
  } state_e;
endpackage

// File: rtl/cfgf_csum.sv
module cfgf_csum #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         bit_en_i,
  input  logic         bit_i,
  output logic [W-1:0] csum_o
);
  localparam int unsigned CW = $clog2(W);

  logic [W-1:0]  sum_q, part_q, part_nxt;
  logic [CW-1:0] fill_q;
  logic [CW:0]   pad;

  function automatic logic [W-1:0] add_wrap(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[W-1:0] + {{(W-1){1'b0}}, s[W]};
  endfunction

  assign part_nxt = {part_q[W-2:0], bit_i};
  assign pad      = (CW+1)'(W) - {1'b0, fill_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      part_q <= '0;
      fill_q <= '0;
    end else if (load_i) begin
      sum_q  <= load_val_i;
      part_q <= '0;
      fill_q <= '0;
    end else if (bit_en_i) begin
      if (fill_q == CW'(W-1)) begin
        sum_q  <= add_wrap(sum_q, part_nxt);
        part_q <= '0;
        fill_q <= '0;
      end else begin
        part_q <= part_nxt;
        fill_q <= fill_q + 1'b1;
      end
    end
  end

  // partial byte is zero padded on the right before the final add
  assign csum_o = ~((fill_q == '0) ? sum_q : add_wrap(sum_q, part_q << pad));
endmodule

// File: rtl/cfgf_pbuf.sv
module cfgf_pbuf
  import cfgf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stg_we_i,
  input  logic [CNT_W-1:0] stg_pos_i,
  input  logic             stg_bit_i,
  input  logic             commit_i,
  input  logic [IDX_W-1:0] commit_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [CNT_W-1:0] rd_pos_i,
  output logic             rd_bit_o
);
  localparam int unsigned TOT_W  = total_len();
  localparam int unsigned STG_W  = stage_len();
  localparam int unsigned STG_AW = $clog2(STG_W);
  localparam int unsigned TOT_AW = $clog2(TOT_W);

  logic [STG_W-1:0] stg_q;
  logic [TOT_W-1:0] flat;
  logic [31:0]      rd_abs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else if (stg_we_i && (32'(stg_pos_i) < STG_W)) stg_q[stg_pos_i[STG_AW-1:0]] <= stg_bit_i;
  end

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_fld
    localparam int unsigned OFF = sub_off(g);
    localparam int unsigned LEN = sub_len(g);
    if (LEN > 0 && sub_wr(g)) begin : g_rw
      logic [LEN-1:0] fld_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fld_q <= '0;
        else if (commit_i && commit_idx_i == IDX_W'(g)) fld_q <= stg_q[LEN-1:0];
      end
      assign flat[OFF +: LEN] = fld_q;
    end else if (LEN > 0) begin : g_ro
      assign flat[OFF +: LEN] = '0;
    end
  end

  assign rd_abs   = sub_off(32'(rd_idx_i)) + 32'(rd_pos_i);
  assign rd_bit_o = (32'(rd_pos_i) < sub_len(32'(rd_idx_i))) ? flat[rd_abs[TOT_AW-1:0]] : 1'b0;

  assert_store_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(flat));
endmodule

// File: rtl/cfg_frame_parser.sv
module cfg_frame_parser
  import cfgf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  input  logic timeout_i,
  output logic tx_valid_o,
  output logic tx_bit_o
);
  localparam int unsigned CMD_W  = IDX_W + 1;
  localparam int unsigned CSEL_W = $clog2(CSUM_W);

  state_e            st_q;
  logic [CNT_W-1:0]  cnt_q, len, nlen, csel;
  logic [CMD_W-1:0]  cmd_q, cmd_nxt;
  logic [CSUM_W-1:0] rxcs_q, rxcs_nxt, calc_cs, load_val;
  logic [IDX_W-1:0]  idx, nidx;
  logic ack_q, cs_ok, commit, acc_load, acc_en, acc_bit, rd_bit;
  logic cmd_done, data_done, cs_done, tx_done, stg_we;

  assign idx       = cmd_q[IDX_W-1:0];
  assign cmd_nxt   = {cmd_q[CMD_W-2:0], bit_i};
  assign nidx      = cmd_nxt[IDX_W-1:0];
  assign len       = CNT_W'(sub_len(32'(idx)));
  assign nlen      = CNT_W'(sub_len(32'(nidx)));
  assign rxcs_nxt  = {rxcs_q[CSUM_W-2:0], bit_i};

  assign cmd_done  = cnt_q == CNT_W'(IDX_W);
  assign data_done = cnt_q == len - 1'b1;
  assign cs_done   = cnt_q == CNT_W'(CSUM_W-1);
  assign tx_done   = cnt_q == len + CNT_W'(CSUM_W-1);

  // read-only and reserved indices fail like a bad checksum
  assign cs_ok  = (rxcs_nxt == calc_cs) && sub_wr(32'(idx));
  assign commit = (st_q == ST_CSUM) && bit_valid_i && cs_done && cs_ok && !timeout_i;

  // read checksum is seeded with the unsent {0000, index} byte
  assign acc_load = ((st_q == ST_IDLE) && frame_start_i) ||
                    ((st_q == ST_CMD) && bit_valid_i && cmd_done && !cmd_nxt[CMD_W-1]);
  assign load_val = (st_q == ST_CMD) ? CSUM_W'(nidx) : '0;
  assign acc_en   = (((st_q == ST_CMD) || (st_q == ST_DATA)) && bit_valid_i) ||
                    ((st_q == ST_READ) && (cnt_q < len));
  assign acc_bit  = (st_q == ST_READ) ? rd_bit : bit_i;
  assign stg_we   = (st_q == ST_DATA) && bit_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      cmd_q  <= '0;
      rxcs_q <= '0;
      ack_q  <= 1'b0;
    end else if (timeout_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (frame_start_i) begin
          st_q  <= ST_CMD;
          cnt_q <= '0;
        end
        ST_CMD: if (bit_valid_i) begin
          cmd_q <= cmd_nxt;
          if (cmd_done) begin
            cnt_q <= '0;
            if (cmd_nxt[CMD_W-1]) st_q <= (nlen == '0) ? ST_CSUM : ST_DATA;
            else                  st_q <= (nlen == '0) ? ST_IDLE : ST_READ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: if (bit_valid_i) begin
          if (data_done) begin
            st_q  <= ST_CSUM;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CSUM: if (bit_valid_i) begin
          rxcs_q <= rxcs_nxt;
          if (cs_done) begin
            st_q  <= ST_ACK;
            ack_q <= cs_ok;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ACK: st_q <= ST_IDLE;
        ST_READ: begin
          if (tx_done) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  cfgf_csum #(.W(CSUM_W)) u_csum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (acc_load),
    .load_val_i (load_val),
    .bit_en_i   (acc_en),
    .bit_i      (acc_bit),
    .csum_o     (calc_cs)
  );

  cfgf_pbuf u_pbuf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stg_we_i     (stg_we),
    .stg_pos_i    (cnt_q),
    .stg_bit_i    (bit_i),
    .commit_i     (commit),
    .commit_idx_i (idx),
    .rd_idx_i     (idx),
    .rd_pos_i     (cnt_q),
    .rd_bit_o     (rd_bit)
  );

  assign csel       = cnt_q - len;
  assign tx_valid_o = (st_q == ST_ACK) || (st_q == ST_READ);
  assign tx_bit_o   = (st_q == ST_ACK) ? ack_q :
                      (cnt_q < len)     ? rd_bit :
                      calc_cs[CSEL_W'(CSUM_W-1) - csel[CSEL_W-1:0]];

  assert_ack_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACK) |=> (st_q == ST_IDLE));
  assert_ack_vs_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ACK) |-> (tx_bit_o == $past(commit)));
  assert_data_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_DATA) && bit_valid_i) |-> (cnt_q < len));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_DATA) && frame_start_i && !bit_valid_i && !timeout_i) |=>
    ((st_q == ST_DATA) && $stable(cnt_q)));
  assert_timeout_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> (st_q == ST_IDLE));
endmodule

// File: tb/cfg_frame_parser_test.sv
module cfg_frame_parser_test;
  logic clk = 1'b0, rst_n = 1'b0, fs = 1'b0, bv = 1'b0, bb = 1'b0, to = 1'b0;
  wire  tv, tb;
  int   n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  logic [1023:0] m_buf [16];
  bit m_act = 1'b0;
  bit m_rx[$];
  bit m_txq[$];
  bit seen[$];

  always #5 clk = ~clk;

  cfg_frame_parser uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .bit_valid_i(bv),
    .bit_i(bb), .timeout_i(to), .tx_valid_o(tv), .tx_bit_o(tb)
  );

  function automatic int tb_len(int i);
    int t[16] = '{8, 24, 8, 18, 8, 124, 124, 42, 56, 160, 46, 8, 1024, 352, 0, 16};
    return t[i];
  endfunction

  function automatic bit tb_ro(int i);
    return i == 0 || i == 1 || i == 12 || i == 14 || i == 15;
  endfunction

  function automatic logic [7:0] tb_csum(bit q[$]);
    int s = 0;
    for (int b = 0; b < (q.size() + 7) / 8; b++) begin
      int by = 0;
      for (int j = 0; j < 8; j++) by = by * 2 + (((b * 8 + j) < q.size()) ? int'(q[b * 8 + j]) : 0);
      s += by;
      if (s > 255) s -= 255;
    end
    return ~(8'(s));
  endfunction

  task automatic model_step();
    int n = m_rx.size();
    int idx;
    if (n < 5) return;
    idx = m_rx[1] * 8 + m_rx[2] * 4 + m_rx[3] * 2 + m_rx[4];
    if (!m_rx[0]) begin
      bit cov[$];
      m_act = 1'b0;
      if (idx == 14) return;
      for (int j = 7; j >= 0; j--) cov.push_back(j < 4 ? 1'(idx >> j) : 1'b0);
      for (int k = 0; k < tb_len(idx); k++) begin
        cov.push_back(m_buf[idx][k]);
        m_txq.push_back(m_buf[idx][k]);
      end
      begin
        logic [7:0] c = tb_csum(cov);
        for (int j = 7; j >= 0; j--) m_txq.push_back(c[j]);
      end
    end else if (n == 5 + tb_len(idx) + 8) begin
      bit cov[$];
      logic [7:0] c, got;
      bit ok;
      for (int p = 0; p < 5 + tb_len(idx); p++) cov.push_back(m_rx[p]);
      c = tb_csum(cov);
      for (int p = 0; p < 8; p++) got[7 - p] = m_rx[n - 8 + p];
      ok = (c == got) && !tb_ro(idx);
      if (ok) for (int k = 0; k < tb_len(idx); k++) m_buf[idx][k] = m_rx[5 + k];
      m_txq.push_back(ok);
      m_act = 1'b0;
    end
  endtask

  // reference model, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 1'b0; m_rx.delete(); m_txq.delete();
      for (int i = 0; i < 16; i++) m_buf[i] = '0;
    end else begin
      bit busy;
      busy = m_act || (m_txq.size() > 0);
      if (m_txq.size() > 0) void'(m_txq.pop_front());
      if (to) begin
        m_act = 1'b0; m_rx.delete(); m_txq.delete();
      end else if (m_act) begin
        if (bv) begin m_rx.push_back(bb); model_step(); end
      end else if (!busy && fs) begin
        m_act = 1'b1; m_rx.delete();
      end
    end
  end

  always @(negedge clk) begin
    bit ev;
    ev = m_txq.size() > 0;
    n_chk++;
    if (tv !== ev || (ev && tb !== m_txq[0])) begin
      n_fail++;
      $display("FAIL %s: tx_valid=%0b tx_bit=%0b expected valid=%0b bit=%0b",
               cur_req, tv, tb, ev, ev ? m_txq[0] : 1'b0);
    end
    if (tv === 1'b1) seen.push_back(tb);
  end

  task automatic chk(bit ok, string req, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic settle();
    while (m_act || m_txq.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // fs_at: start pulse before that bit; to_at: timeout after that bit, frame abandoned
  task automatic drive(bit q[$], int gap, int fs_at, int to_at);
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
    foreach (q[i]) begin
      if (i == fs_at) begin fs = 1'b1; @(negedge clk); fs = 1'b0; end
      bv = 1'b1; bb = q[i];
      @(negedge clk); bv = 1'b0;
      if (i == to_at) begin to = 1'b1; @(negedge clk); to = 1'b0; return; end
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic mk_write(int idx, bit d[$], bit bad, output bit q[$]);
    logic [7:0] c;
    q.delete();
    q.push_back(1'b1);
    for (int j = 3; j >= 0; j--) q.push_back(1'(idx >> j));
    foreach (d[i]) q.push_back(d[i]);
    c = tb_csum(q);
    if (bad) c ^= 8'h01;
    for (int j = 7; j >= 0; j--) q.push_back(c[j]);
  endtask

  task automatic wr(string req, int idx, bit d[$], bit bad, int gap, bit exp_ack);
    bit q[$];
    cur_req = req;
    mk_write(idx, d, bad, q);
    seen.delete();
    drive(q, gap, -1, -1);
    settle();
    chk(seen.size() == 1 && seen[0] == exp_ack, {req, " ack"}, seen.size() ? int'(seen[0]) : -1, exp_ack);
  endtask

  task automatic rd(string req, int idx, int extra);
    bit q[$];
    int exp_n;
    cur_req = req;
    q.push_back(1'b0);
    for (int j = 3; j >= 0; j--) q.push_back(1'(idx >> j));
    repeat (extra) q.push_back(1'b1);
    seen.delete();
    drive(q, 0, -1, -1);
    settle();
    exp_n = (idx == 14) ? 0 : tb_len(idx) + 8;
    chk(seen.size() == exp_n, {req, " read length"}, seen.size(), exp_n);
  endtask

  function automatic void rbits(int n, output bit d[$]);
    d.delete();
    for (int i = 0; i < n; i++) d.push_back(1'($urandom));
  endfunction

  function automatic int seen_byte(int from);
    int v = 0;
    for (int i = 0; i < 8; i++) v = v * 2 + ((from + i < seen.size()) ? int'(seen[from + i]) : 0);
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    bit d[$];
    bit q[$];
    repeat (3) @(negedge clk);
    chk(tv === 1'b0, "R1 tx_valid in reset", tv, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tv === 1'b0, "R1 tx_valid after reset", tv, 0);

    rd("R1", 2, 0);
    chk(seen_byte(0) == 0, "R1 reset field", seen_byte(0), 0);

    // R5 / R8 / R4: 0xA5 into index 2, read checksum ~(0x02+0xA5)=0x58
    d = '{1, 0, 1, 0, 0, 1, 0, 1};
    wr("R5", 2, d, 1'b0, 0, 1'b1);
    rd("R8", 2, 0);
    chk(seen_byte(0) == 'hA5, "R8 data order", seen_byte(0), 'hA5);
    chk(seen_byte(8) == 'h58, "R4 read checksum", seen_byte(8), 'h58);

    // R3: odd lengths exercise zero padding; R12: spaced bits
    rbits(18, d); wr("R3", 3, d, 1'b0, 0, 1'b1); rd("R3", 3, 0);
    rbits(42, d); wr("R12", 7, d, 1'b0, 3, 1'b1); rd("R12", 7, 0);
    rbits(352, d); wr("R3", 13, d, 1'b0, 0, 1'b1); rd("R4", 13, 0);
    rbits(160, d); wr("R5", 9, d, 1'b0, 1, 1'b1);

    // R6: bad checksum leaves 0xA5 in place
    d = '{0, 1, 1, 1, 0, 0, 0, 0};
    wr("R6", 2, d, 1'b1, 0, 1'b0);
    rd("R6", 2, 0);
    chk(seen_byte(0) == 'hA5, "R6 field kept", seen_byte(0), 'hA5);

    // R7: read-only and reserved targets
    rbits(8, d);  wr("R7", 0, d, 1'b0, 0, 1'b0);
    rd("R7", 0, 0);
    chk(seen_byte(0) == 0, "R7 read-only field", seen_byte(0), 0);
    d.delete();   wr("R7", 14, d, 1'b0, 0, 1'b0);
    rbits(16, d); wr("R7", 15, d, 1'b0, 0, 1'b0);

    rd("R8", 14, 0);
    rd("R8", 12, 0);
    rd("R8", 1, 0);

    // R9: surplus bits after a write and during a read
    cur_req = "R9";
    rbits(8, d); mk_write(4, d, 1'b0, q);
    repeat (6) q.push_back(1'b1);
    seen.delete(); drive(q, 0, -1, -1); settle();
    chk(seen.size() == 1 && seen[0] == 1'b1, "R9 ack with surplus", seen.size(), 1);
    rd("R9", 4, 12);

    // R10: start pulse mid data field
    cur_req = "R10";
    d = '{1, 1, 0, 0, 1, 1, 0, 0}; mk_write(11, d, 1'b0, q);
    seen.delete(); drive(q, 0, 8, -1); settle();
    chk(seen.size() == 1 && seen[0] == 1'b1, "R10 ack", seen.size(), 1);
    rd("R10", 11, 0);
    chk(seen_byte(0) == 'hCC, "R10 field", seen_byte(0), 'hCC);

    // R11: timeout in the data field, then during a long read
    cur_req = "R11";
    rbits(160, d); mk_write(9, d, 1'b0, q);
    seen.delete(); drive(q, 0, -1, 40); settle();
    chk(seen.size() == 0, "R11 no ack", seen.size(), 0);
    rd("R11", 9, 0);
    q = '{0, 1, 1, 0, 1};
    seen.delete(); drive(q, 0, -1, -1);
    repeat (20) @(negedge clk);
    to = 1'b1; @(negedge clk); to = 1'b0;
    settle();
    chk(seen.size() < 360 && seen.size() > 0, "R11 read cut", seen.size(), 21);
    rd("R2", 2, 0);
    chk(seen_byte(0) == 'hA5, "R2 frame after abort", seen_byte(0), 'hA5);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule